// File: doc/BRIEF.md
# Transaction Order Sequence Checker

This block confirms that a mixed stream of write requests and doorbell messages comes out of a link in the order it went in. Two recorders sit on either side of the link. The issue recorder logs a one-bit type tag for every transaction the source launches. The receive recorder logs a tag for every transaction that emerges after the link. A write is tagged 0 and a doorbell is tagged 1.

Once each side has logged a fixed number of tags (`DEPTH`, 40 by default), the two tag sequences are compared bit by bit. `done` then rises, and `match` reports whether the sequences agree exactly. Payload contents are not examined. Any transaction beyond the capacity of either recorder raises a sticky error and is discarded. Each side has one strobe for writes and one for doorbells. When both strobes of a side fire in the same cycle, the write is logged first.

Top module: `txn_order_checker`

## Requirements
- R1: A synchronous active-high reset clears `done_o`, `match_o` and `err_o`, and empties both recorders.
- R2: Each recorder stores tag 0 for a write strobe and tag 1 for a doorbell strobe. Entry k is the (k+1)-th event logged on that side, counted from reset.
- R3: If the write and doorbell strobes of one side are both high in one cycle, the write tag takes the lower position and the doorbell tag takes the next one.
- R4: `done_o` rises one clock cycle after the edge at which the later of the two recorders reaches `DEPTH` entries.
- R5: When `done_o` is high, `match_o` is 1 only if the two `DEPTH`-entry tag sequences are equal at every position. Otherwise it is 0. `match_o` is 0 whenever `done_o` is 0.
- R6: Once `done_o` is high, `done_o` and `match_o` keep their values until reset.
- R7: A strobe that finds its recorder already holding `DEPTH` entries sets `err_o` at that clock edge. If a same-cycle pair finds only one free entry, the write is stored and the doorbell overflows.
- R8: `err_o` stays high until reset. Discarded overflow tags do not change `done_o` or `match_o`.
- R9: `done_o` stays low while either recorder holds fewer than `DEPTH` entries, even if the other one is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_wr_i | input | 1 | Write issued before the link |
| iss_db_i | input | 1 | Doorbell issued before the link |
| rcv_wr_i | input | 1 | Write received after the link |
| rcv_db_i | input | 1 | Doorbell received after the link |
| done_o | output | 1 | Comparison finished |
| match_o | output | 1 | Sequences matched exactly (valid when done_o is high) |
| err_o | output | 1 | Sticky overflow on either recorder |

## Verification
A recorder with a corrupted fill count shows up within one cycle. `done_o` rises too early, or too late compared with the final strobe, or `err_o` fires before capacity is reached. A wrongly stored tag, or a same-cycle pair stored in the wrong order, stays hidden until the comparison. It then appears as a flipped `match_o` one cycle after both recorders fill. The tests therefore include streams that differ in a single position and paired-strobe streams checked against serial streams.

// File: rtl/txn_order_pkg.sv
package txn_order_pkg;
  typedef enum logic {
    TAG_WRITE    = 1'b0,
    TAG_DOORBELL = 1'b1
  } tag_e;
endpackage

// File: rtl/tag_queue.sv
module tag_queue
  import txn_order_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ev,
  input  logic             db_ev,
  output logic [DEPTH-1:0] tags_o,
  output logic             full_o,
  output logic             ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] mem;
  logic [1:0]       n_ev;
  logic [1:0]       take;
  logic [CW:0]      room;
  logic [CW:0]      n_ev_w;
  logic [CW:0]      nxt1;
  tag_e             first_tag;
  logic             spill;

  always_comb begin
    n_ev      = {1'b0, wr_ev} + {1'b0, db_ev};
    n_ev_w    = (CW+1)'(n_ev);
    room      = (CW+1)'(DEPTH) - {1'b0, cnt};
    spill     = n_ev_w > room;
    take      = spill ? room[1:0] : n_ev;
    nxt1      = {1'b0, cnt} + (CW+1)'(1);
    first_tag = wr_ev ? TAG_WRITE : TAG_DOORBELL;
  end

  // Fill count and sticky overflow flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ovf_o <= 1'b0;
    end else begin
      cnt <= cnt + CW'(take);
      if (spill) ovf_o <= 1'b1;
    end
  end

  // Tag storage: no reset, every slot is written before it is compared
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (n_ev != 2'd0 && {1'b0, cnt} == (CW+1)'(i))
        mem[i] <= first_tag;
      else if (n_ev == 2'd2 && nxt1 == (CW+1)'(i))
        mem[i] <= TAG_DOORBELL;
    end
  end

  assign tags_o = mem;
  assign full_o = (cnt == CW'(DEPTH));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
    full_o |=> full_o);
  p_ovf_only_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> full_o);
endmodule

// File: rtl/seq_compare.sv
module seq_compare #(
  parameter int DEPTH = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_a,
  input  logic             full_b,
  input  logic [DEPTH-1:0] seq_a,
  input  logic [DEPTH-1:0] seq_b,
  output logic             done_o,
  output logic             match_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else if (!done_o && full_a && full_b) begin
      done_o  <= 1'b1;
      match_o <= (seq_a == seq_b);
    end
  end

  p_done_needs_full_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (full_a && full_b));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  p_match_stable_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> $stable(match_o));
  p_match_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
    match_o |-> done_o);
endmodule

// File: rtl/txn_order_checker.sv
module txn_order_checker #(
  parameter int DEPTH = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic iss_wr_i,
  input  logic iss_db_i,
  input  logic rcv_wr_i,
  input  logic rcv_db_i,
  output logic done_o,
  output logic match_o,
  output logic err_o
);
  logic [DEPTH-1:0] iss_tags, rcv_tags;
  logic             iss_full, rcv_full;
  logic             iss_ovf, rcv_ovf;

  tag_queue #(.DEPTH(DEPTH)) u_iss_q (
    .clk(clk), .rst(rst), .wr_ev(iss_wr_i), .db_ev(iss_db_i),
    .tags_o(iss_tags), .full_o(iss_full), .ovf_o(iss_ovf)
  );

  tag_queue #(.DEPTH(DEPTH)) u_rcv_q (
    .clk(clk), .rst(rst), .wr_ev(rcv_wr_i), .db_ev(rcv_db_i),
    .tags_o(rcv_tags), .full_o(rcv_full), .ovf_o(rcv_ovf)
  );

  seq_compare #(.DEPTH(DEPTH)) u_cmp (
    .clk(clk), .rst(rst), .full_a(iss_full), .full_b(rcv_full),
    .seq_a(iss_tags), .seq_b(rcv_tags), .done_o(done_o), .match_o(match_o)
  );

  assign err_o = iss_ovf | rcv_ovf;

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!done_o && !match_o && !err_o));
endmodule

// File: tb/txn_order_checker_tb.sv
module txn_order_checker_tb;
  localparam int D = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iw = 1'b0, id = 1'b0, rw = 1'b0, rd = 1'b0;
  logic done, match, err;
  int   n_chk = 0;
  int   n_err = 0;
  bit   ended = 1'b0;

  always #2.5 clk = ~clk;

  txn_order_checker #(.DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .iss_wr_i(iw), .iss_db_i(id),
    .rcv_wr_i(rw), .rcv_db_i(rd),
    .done_o(done), .match_o(match), .err_o(err)
  );

  function automatic logic pat(int i);
    return ((i * 5 + 3) % 7) < 3;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic a, logic b, logic c, logic e);
    @(negedge clk);
    iw = a; id = b; rw = c; rd = e;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iw = 0; id = 0; rw = 0; rd = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Tag = pattern bit: 1 drives doorbell, 0 drives write
  task automatic run_stream(int lag, int flip_idx);
    for (int c = 0; c < D + lag; c++) begin
      logic it, rt;
      logic iv, rv;
      iv = c < D;
      rv = c >= lag;
      it = pat(c);
      rt = pat(c - lag) ^ ((c - lag) == flip_idx);
      step(iv & ~it, iv & it, rv & ~rt, rv & rt);
    end
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done after reset", done, 1'b0);
    chk("R1 match after reset", match, 1'b0);
    chk("R1 err after reset", err, 1'b0);
  endtask

  task automatic t_lagged_match();
    do_reset();
    run_stream(3, -1);
    chk("R4 done not yet one cycle early", done, 1'b0);
    idle();
    chk("R4 done after both full", done, 1'b1);
    chk("R2 R5 identical streams match", match, 1'b1);
    chk("R7 no overflow", err, 1'b0);
  endtask

  task automatic t_write_then_doorbell();
    do_reset();
    for (int i = 0; i < D / 2; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1);
    end
    idle();
    idle();
    chk("R4 done alternating", done, 1'b1);
    chk("R5 alternating match", match, 1'b1);
  endtask

  task automatic t_mismatch();
    do_reset();
    run_stream(0, 17);
    idle();
    chk("R4 done with mismatch", done, 1'b1);
    chk("R5 single flipped tag", match, 1'b0);
    repeat (5) idle();
    chk("R6 done held", done, 1'b1);
    chk("R6 mismatch latched", match, 1'b0);
  endtask

  task automatic t_one_side_full();
    do_reset();
    for (int i = 0; i < D; i++) step(1'b1, 1'b0, i < D - 1, 1'b0);
    repeat (4) idle();
    chk("R9 no done with one side short", done, 1'b0);
    chk("R9 match low", match, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    idle();
    chk("R4 done not same cycle", done, 1'b0);
    idle();
    chk("R4 done after late fill", done, 1'b1);
    chk("R5 late fill match", match, 1'b1);
  endtask

  task automatic t_paired(logic db_first);
    do_reset();
    for (int i = 0; i < D; i++) begin
      logic rt;
      rt = (i % 2 == 1) ^ db_first;
      step(i < D / 2, i < D / 2, ~rt, rt);
    end
    idle();
    idle();
    chk("R3 done paired", done, 1'b1);
    chk("R3 paired strobes write first", match, ~db_first);
  endtask

  task automatic t_overflow_after_done();
    do_reset();
    run_stream(0, -1);
    idle();
    chk("R5 base match", match, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R7 extra issue overflows", err, 1'b1);
    chk("R8 done unaffected", done, 1'b1);
    chk("R8 match unaffected", match, 1'b1);
    repeat (3) idle();
    chk("R8 err sticky", err, 1'b1);
    do_reset();
    chk("R1 err cleared", err, 1'b0);
    chk("R1 done cleared", done, 1'b0);
  endtask

  task automatic t_boundary_pair();
    do_reset();
    for (int i = 0; i < D - 1; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    chk("R7 no err below capacity", err, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    idle();
    chk("R7 pair with one slot overflows", err, 1'b1);
    idle();
    chk("R4 done boundary", done, 1'b1);
    chk("R7 write kept doorbell dropped", match, 1'b1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_lagged_match();
    t_write_then_doorbell();
    t_mismatch();
    t_one_side_full();
    t_paired(1'b0);
    t_paired(1'b1);
    t_overflow_after_done();
    t_boundary_pair();
    finish_run();
  end
endmodule